// File: doc/BRIEF.md
# Block Register Transfer Address Sequencer

This block turns one load/store-multiple command into a series of single-word memory transfers. A command carries a base address, a 16-bit register selection mask and four control bits: pre/post indexing, ascending/descending direction, base write-back enable and load/store direction. A privileged-bank flag is carried through to every transfer unchanged. The register file and memory live outside the block. The block only works out which register goes to which address, and in what order.

The block accepts a command with a one-cycle `start` pulse while it is idle. It then presents one request at a time on a valid/acknowledge bus. Each request gives the word address, the register index and the direction. A request holds until `req_ack` is seen at a clock edge. The registers are always issued from the lowest index up, and the addresses rise by one word each time, so the lowest register meets the lowest address in every mode. After the last acknowledge, `done` pulses for one cycle. When write-back is enabled, `wb_valid` pulses together with `done` and `wb_value` carries the updated base. An empty mask is refused with a one-cycle `err` pulse and produces no requests.

Top module: `blk_xfer_seq`

## Requirements
- R1: Mask bit i selects register i. Exactly one request is issued per set bit, with `req_reg` equal to i, in strictly increasing register order.
- R2: A command with an all-zero mask pulses `err` in the cycle after `start`, never raises `req_valid` and never pulses `done`.
- R3: Ascending, post-indexed (up=1, pre=0): the first address equals the base.
- R4: Ascending, pre-indexed (up=1, pre=1): the first address equals base+4.
- R5: Descending, post-indexed (up=0, pre=0): the first address equals base-4n+4, where n is the number of set mask bits.
- R6: Descending, pre-indexed (up=0, pre=1): the first address equals base-4n.
- R7: Each later request's address is 4 above the previous one, so the lowest-numbered register goes to the lowest address.
- R8: With write-back enabled, `wb_valid` pulses with `done` and `wb_value` is base+4n when ascending or base-4n when descending. With write-back disabled, `wb_valid` stays low.
- R9: While `req_valid` is high and `req_ack` is low, the request's address, register index and flags hold steady.
- R10: `done` is a one-cycle pulse in the cycle after the last acknowledge, and `req_valid` is low while `done` is high.
- R11: A `start` pulse while a command is in progress is ignored and does not alter the running sequence.
- R12: `req_load` equals the command's load bit (1 = load, 0 = store) and `req_user` equals its privileged-bank flag on every request.
- R13: After reset, `req_valid`, `done`, `err`, `wb_valid` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when idle |
| base_addr | input | 32 | Base address of the command |
| reg_mask | input | 16 | Register selection mask |
| pre_idx | input | 1 | 1 = step before transfer, 0 = step after |
| up_dir | input | 1 | 1 = ascending, 0 = descending |
| wb_en | input | 1 | Return the updated base at the end |
| load_dir | input | 1 | 1 = load, 0 = store |
| user_bank | input | 1 | Privileged-bank flag passed to each request |
| busy | output | 1 | A command is in progress |
| req_valid | output | 1 | Transfer request present |
| req_addr | output | 32 | Word address of the request |
| req_reg | output | 4 | Register index of the request |
| req_load | output | 1 | Direction of the request |
| req_user | output | 1 | Privileged-bank flag of the request |
| req_ack | input | 1 | Transfer accepted at this edge |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | One-cycle empty-mask refusal pulse |
| wb_valid | output | 1 | Write-back value valid, with done |
| wb_value | output | 32 | Updated base value |

## Verification
The hardest case to reach from the ports is a descending command with a sparse, high-heavy mask. In that case the first address lies several words below the base, while the register indices still have to climb. The stimulus table therefore mixes single-bit, full, alternating and top-only masks across all four modes. Some bases sit near zero and near the top of the address space, so the descending arithmetic wraps. Acknowledges arrive after a delay of 0 to 2 cycles that varies by transfer, so the request must hold through several stall lengths. A second `start` pulse is fired in the middle of a command to show that it is ignored.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          base_addr,
  input  logic [NREG-1:0]            reg_mask,
  input  logic                       pre_idx,
  input  logic                       up_dir,
  input  logic                       wb_en,
  input  logic                       load_dir,
  input  logic                       user_bank,
  output logic                       busy,
  output logic                       req_valid,
  output logic [ADDR_W-1:0]          req_addr,
  output logic [$clog2(NREG)-1:0]    req_reg,
  output logic                       req_load,
  output logic                       req_user,
  input  logic                       req_ack,
  output logic                       done,
  output logic                       err,
  output logic                       wb_valid,
  output logic [ADDR_W-1:0]          wb_value
);
  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = $clog2(NREG + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [NREG-1:0]   left_q;
  logic [ADDR_W-1:0] addr_q, wbv_q;
  logic              busy_q, wben_q, load_q, user_q, done_q, err_q, wbp_q;

  function automatic logic [CNT_W-1:0] pop(input logic [NREG-1:0] m);
    logic [CNT_W-1:0] c = '0;
    for (int i = 0; i < NREG; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  function automatic logic [IDX_W-1:0] lowest(input logic [NREG-1:0] m);
    logic [IDX_W-1:0] r = '0;
    for (int i = NREG - 1; i >= 0; i--) if (m[i]) r = IDX_W'(i);
    return r;
  endfunction

  wire [ADDR_W-1:0] span  = ADDR_W'(pop(reg_mask)) * STEP;
  wire [ADDR_W-1:0] first = up_dir ? base_addr + (pre_idx ? STEP : '0)
                                   : base_addr - span + (pre_idx ? '0 : STEP);
  wire [ADDR_W-1:0] final_base = up_dir ? base_addr + span : base_addr - span;
  wire [IDX_W-1:0]  cur   = lowest(left_q);
  wire              last  = (left_q & (left_q - 1'b1)) == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0; addr_q <= '0; wbv_q <= '0;
      busy_q <= 1'b0; wben_q <= 1'b0; load_q <= 1'b0; user_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; wbp_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      wbp_q  <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (reg_mask == '0) begin
            err_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            left_q <= reg_mask;
            addr_q <= first;
            wbv_q  <= final_base;
            wben_q <= wb_en;
            load_q <= load_dir;
            user_q <= user_bank;
          end
        end
      end else if (req_ack) begin
        left_q <= left_q & ~(NREG'(1) << cur);
        addr_q <= addr_q + STEP;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          wbp_q  <= wben_q;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign req_valid = busy_q;
  assign req_addr  = addr_q;
  assign req_reg   = cur;
  assign req_load  = load_q;
  assign req_user  = user_q;
  assign done      = done_q;
  assign err       = err_q;
  assign wb_valid  = wbp_q;
  assign wb_value  = wbv_q;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_reg)
                              && $stable(req_load) && $stable(req_user));
  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ack |=> !req_valid || req_addr == $past(req_addr) + STEP);
  assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ack |=> !req_valid || req_reg > $past(req_reg));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !req_valid && !done);
  assert_wb_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);
endmodule

// File: tb/blk_xfer_seq_test.sv
module blk_xfer_seq_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_mask = '0;
  logic pre_idx = 0, up_dir = 0, wb_en = 0, load_dir = 0, user_bank = 0, req_ack = 0;
  logic busy, req_valid, req_load, req_user, done, err, wb_valid;
  logic [31:0] req_addr, wb_value;
  logic [3:0]  req_reg;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  blk_xfer_seq uut (.clk, .rst_n, .start, .base_addr, .reg_mask, .pre_idx, .up_dir,
    .wb_en, .load_dir, .user_bank, .busy, .req_valid, .req_addr, .req_reg, .req_load,
    .req_user, .req_ack, .done, .err, .wb_valid, .wb_value);

  // {base, mask, pre, up, wb, load, user}
  localparam logic [52:0] VEC [12] = '{
    {32'h0000_1000, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'h0000_1000, 16'h8421, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {32'h0000_2000, 16'h00F0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {32'h0000_2000, 16'hA005, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_4000, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {32'h0000_4000, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_0008, 16'h5555, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {32'hFFFF_FFF0, 16'hAAAA, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {32'h0000_0100, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {32'h0000_0100, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h1234_5678, 16'h0180, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {32'h0000_0040, 16'hC003, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int k = 0; k < 20; k++) begin
      if (req_valid) begin ok = 1; return; end
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [52:0] v, input bit poke);
    logic [31:0] b = v[52:21];
    logic [15:0] m = v[20:5];
    bit p = v[4], u = v[3], w = v[2], l = v[1], s = v[0];
    int n = 0, seen = 0;
    logic [31:0] a, wb;
    bit ok;
    string mode;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    if (u) begin a = p ? b + 4 : b; wb = b + 32'(4 * n); mode = p ? "R4" : "R3"; end
    else   begin a = p ? b - 32'(4 * n) : b - 32'(4 * n) + 4; wb = b - 32'(4 * n); mode = p ? "R6" : "R5"; end
    @(negedge clk);
    base_addr = b; reg_mask = m; pre_idx = p; up_dir = u; wb_en = w; load_dir = l; user_bank = s;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 16; i++) begin
      if (!m[i]) continue;
      wait_valid(ok);
      chk(ok, "R1 request present", 32'(req_valid), 32'd1);
      chk(req_reg == 4'(i), "R1 register index", 32'(req_reg), 32'(i));
      chk(req_addr == a, seen == 0 ? mode : "R7", req_addr, a);
      chk(req_load == l && req_user == s, "R12 flags", {30'd0, req_load, req_user}, {30'd0, l, s});
      if (poke && seen == 0) begin
        reg_mask = 16'h0000; start = 1;
        @(negedge clk);
        start = 0;
        chk(!err && req_valid && req_reg == 4'(i) && req_addr == a, "R11 start ignored",
            req_addr, a);
      end
      for (int d = 0; d < (i % 3); d++) begin
        @(negedge clk);
        chk(req_valid && req_addr == a && req_reg == 4'(i), "R9 hold", req_addr, a);
      end
      req_ack = 1;
      @(negedge clk);
      req_ack = 0;
      a = a + 4;
      seen++;
      if (seen < n) chk(!done, "R10 no early done", 32'(done), 32'd0);
    end
    chk(done && !req_valid, "R10 done pulse", {30'd0, done, req_valid}, 32'b10);
    chk(wb_valid == w, "R8 write-back strobe", 32'(wb_valid), 32'(w));
    if (w) chk(wb_value == wb, "R8 write-back value", wb_value, wb);
    @(negedge clk);
    chk(!done && !wb_valid, "R10 done one cycle", 32'(done), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_valid && !done && !err && !wb_valid && !busy, "R13 reset outputs",
        {27'd0, req_valid, done, err, wb_valid, busy}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    foreach (VEC[k]) run(VEC[k], 0);
    run({32'h0000_3000, 16'h0306, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, 1);
    // R2: empty mask refused
    base_addr = 32'h500; reg_mask = '0; pre_idx = 1; up_dir = 1; wb_en = 1; start = 1;
    @(negedge clk);
    start = 0;
    chk(err && !req_valid && !busy, "R2 err pulse", {29'd0, err, req_valid, busy}, 32'b100);
    @(negedge clk);
    chk(!err && !req_valid && !done && !wb_valid, "R2 no transfers",
        {28'd0, err, req_valid, done, wb_valid}, 32'd0);
    repeat (3) begin
      @(negedge clk);
      chk(!req_valid && !done, "R2 stays idle", 32'(req_valid), 32'd0);
    end
    run({32'h0000_0800, 16'h0010, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule